// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the device side of a three-wire serial memory. It runs on the serial clock, and the chip-select line frames each command. With chip select high, it waits for a start bit. It then shifts in a two-bit opcode, an address and, for the writing commands, a data word. It decodes seven commands: read, write, erase, erase-all, write-all, program-enable and program-disable.

A read sends a dummy zero first and then the addressed word, most significant bit first. A programming command hands a request to a program controller that runs by itself. During that time the output pin reports busy or ready. A plain synchronous RAM model holds the data.

An organization input picks 16-bit words or 8-bit words. Programming starts on the edge that captures the last bit of the command. If chip select drops before that edge, the command is cancelled. A programming command is accepted only after a program-enable command.

Top module: `ser_eeprom_cmd`

## Requirements
- R1: While chip select is high, the first 1 sampled on `din` at a rising clock edge is the start bit. Zeros sampled before it are ignored and cause no output.
- R2: The two bits after the start bit are the opcode, first bit most significant. The codes are 10 read, 01 write, 11 erase and 00 extended. For an extended command, the two most significant address bits select the action: 11 enable, 00 disable, 10 erase-all, 01 write-all. The remaining address bits are don't-care.
- R3: With `org_wide` = 1, the array holds 1024 words of 16 bits and takes a 10-bit address. With `org_wide` = 0, it holds 2048 bytes and takes an 11-bit address. Byte address a maps to word a>>1: odd a is the upper byte and even a is the lower byte.
- R4: Read timing is as follows.
  - The edge that captures the last address bit turns the output on and drives a 0.
  - Each following edge drives the next data bit, most significant first.
  - The edge after the least significant bit turns the output off.
- R5: Erase sets the addressed word to all ones, and its request fires on the edge that captures the last address bit. Write stores the data word, and its request fires on the edge that captures the last data bit.
- R6: Erase-all sets every word to all ones. Write-all stores the data pattern in every word; in byte mode, the byte is written to both halves. The busy period lasts 1024 cycles (one cycle per word).
- R7: If chip select falls before the final bit of a programming command, the command is cancelled. No word changes and no status appears.
- R8: Chip select low turns the output off and clears the partly received command at the next clock edge. A fresh command then decodes normally. After reset the output is off.
- R9: A program-enable flag is cleared at reset. The enable command sets it and the disable command clears it. Erase, write, erase-all and write-all do nothing while it is clear. Reads work either way.
- R10: After a programming request, the output shows status whenever chip select is high: 0 while busy and 1 when ready. A single-word operation is busy for 8 cycles after the launch edge. Toggling chip select does not disturb the operation. A start bit taken while ready clears the status and turns the output off.
- R11: Start bits and command bits that arrive while programming is busy are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high frames a command |
| din | input | 1 | Serial data in |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| dout | output | 1 | Serial data out or ready status |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bench aims at the following corner cases:
- **Read timing.** It checks the dummy zero and the exact edge where the output turns off after the last bit. A design that skips the dummy bit shifts every data bit by one position.
- **Cancelled and disabled commands.** It drops chip select one bit before the end of a write, and it sends writes and erases while the enable flag is clear. A design that launches on chip select or ignores the flag corrupts a word that the bench reads back.
- **Commands during busy.** During a long erase-all or write-all, it clocks in a burst of ones that would form an erase if decoded. A design that accepts them erases the last word.
- **Byte mode.** It checks the byte-lane mapping and the 9 don't-care bits of the extended command. A wrong lane or a wrong count shows up as wrong data on readback.

// File: rtl/ser_eeprom_pkg.sv
// Shared types for the serial EEPROM command front-end.
// Assumes: opcode and extended-action encodings are fixed by the serial protocol.
package ser_eeprom_pkg;

    // Frame decoder phases
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADDR,
        FS_DATA,
        FS_READ,
        FS_HOLD
    } fs_t;

    // Programming operations handed to the program controller
    typedef enum logic [1:0] {
        PO_WRITE,
        PO_ERASE,
        PO_WRALL,
        PO_ERALL
    } pop_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_EN    = 2'b11;

endpackage

// File: rtl/ser_eeprom_ram.sv
// Storage array: WORDS entries split into two byte lanes, one write port with
// lane enables and one registered read port.
// Assumes: WIDTH is even; contents are undefined until programmed.
module ser_eeprom_ram #(
    parameter int WORDS = 1024,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [1:0]               wbe,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     re,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    localparam int LW = WIDTH / 2;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LW-1:0] mem [WORDS];

        // Lane write and registered lane read
        always_ff @(posedge clk) begin
            if (we && wbe[g]) begin
                mem[waddr] <= wdata[g*LW +: LW];
            end
            if (re) begin
                rdata[g*LW +: LW] <= mem[raddr];
            end
        end
    end

endmodule

// File: rtl/ser_eeprom_prog.sv
// Program controller: accepts one request while idle, then stays busy.
//   Single-word operations: write the word in the first busy cycle, stay busy
//   for PROG_CYCLES cycles.
//   Bulk operations: write one word per cycle, busy for WORDS cycles.
// Assumes: the front-end never raises a request while busy is high.
module ser_eeprom_prog
    import ser_eeprom_pkg::*;
#(
    parameter int WORDS       = 1024,
    parameter int WIDTH       = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       org_wide,
    input  logic                       req_valid,
    input  pop_t                       req_op,
    input  logic [$clog2(WORDS):0]     req_addr,
    input  logic [WIDTH-1:0]           req_data,
    output logic                       busy,
    output logic                       we,
    output logic [1:0]                 wbe,
    output logic [$clog2(WORDS)-1:0]   waddr,
    output logic [WIDTH-1:0]           wdata
);
    localparam int AWW  = $clog2(WORDS);
    localparam int AWN  = AWW + 1;
    localparam int NW   = WIDTH / 2;
    localparam int MAXT = (WORDS > PROG_CYCLES) ? WORDS : PROG_CYCLES;
    localparam int TW   = $clog2(MAXT);

    logic          bulk;
    logic [TW-1:0] tick;
    logic [TW-1:0] last_tick;
    logic [AWW-1:0] word;
    logic [WIDTH-1:0] pat;
    logic [1:0]    be;
    logic          new_bulk;

    // Whether the incoming request covers the whole array
    assign new_bulk  = (req_op == PO_WRALL) || (req_op == PO_ERALL);

    // Final busy cycle for the running operation
    assign last_tick = bulk ? TW'(WORDS - 1) : TW'(PROG_CYCLES - 1);

    // Accept a request, then count busy cycles until done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bulk <= 1'b0;
            tick <= '0;
            word <= '0;
            pat  <= '0;
            be   <= 2'b00;
        end else if (!busy) begin
            if (req_valid) begin
                busy <= 1'b1;
                tick <= '0;
                bulk <= new_bulk;
                word <= org_wide ? req_addr[AWW-1:0] : req_addr[AWN-1:1];
                if ((req_op == PO_ERASE) || (req_op == PO_ERALL)) begin
                    pat <= '1;
                end else begin
                    pat <= org_wide ? req_data : {2{req_data[NW-1:0]}};
                end
                if (org_wide || new_bulk) begin
                    be <= 2'b11;
                end else begin
                    be <= req_addr[0] ? 2'b10 : 2'b01;
                end
            end
        end else begin
            tick <= tick + 1'b1;
            if (tick == last_tick) begin
                busy <= 1'b0;
            end
        end
    end

    // Array write port drive
    assign we    = busy && (bulk || (tick == '0));
    assign wbe   = be;
    assign waddr = bulk ? tick[AWW-1:0] : word;
    assign wdata = pat;

endmodule

// File: rtl/ser_eeprom_front.sv
// Serial frame decoder.
//   Finds the start bit, shifts in opcode, address and data, and decodes the
//   seven commands.
//   Drives read data or ready status on the output.
//   Raises a one-cycle programming request on the final bit of a programming
//   command.
// Assumes: org_wide is steady during a frame; cs is synchronous to clk.
module ser_eeprom_front
    import ser_eeprom_pkg::*;
#(
    parameter int WORDS = 1024,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs,
    input  logic                     din,
    input  logic                     org_wide,
    input  logic                     busy,
    input  logic [WIDTH-1:0]         rd_q,
    output logic                     rd_req,
    output logic [$clog2(WORDS)-1:0] rd_word,
    output logic                     req_valid,
    output pop_t                     req_op,
    output logic [$clog2(WORDS):0]   req_addr,
    output logic [WIDTH-1:0]         req_data,
    output logic                     dout,
    output logic                     dout_oe
);
    localparam int AWW  = $clog2(WORDS);
    localparam int AWN  = AWW + 1;
    localparam int NW   = WIDTH / 2;
    localparam int MAXV = (AWN > WIDTH) ? AWN : WIDTH;
    localparam int CW   = $clog2(MAXV + 1);

    fs_t             st;
    logic [CW-1:0]   cnt;
    logic [1:0]      opc;
    logic [AWN-1:0]  asr;
    logic [WIDTH-2:0] dsr;
    logic [WIDTH-1:0] osr;
    logic            dummy;
    logic            lane;
    logic            prog_en;
    logic            show_stat;

    logic [CW-1:0]   aw;
    logic [CW-1:0]   dw;
    logic [AWN-1:0]  a_full;
    logic [WIDTH-1:0] d_full;
    logic [1:0]      ext;
    logic            last_a;
    logic            last_d;
    logic            launch_a;

    // Field lengths for the selected organization
    assign aw = org_wide ? CW'(AWW) : CW'(AWN);
    assign dw = org_wide ? CW'(WIDTH) : CW'(NW);

    // Fields including the bit on din this cycle
    assign a_full = {asr[AWN-2:0], din};
    assign d_full = {dsr, din};
    assign ext    = org_wide ? a_full[AWW-1:AWW-2] : a_full[AWN-1:AWN-2];
    assign last_a = (st == FS_ADDR) && (cnt == aw - 1'b1);
    assign last_d = (st == FS_DATA) && (cnt == dw - 1'b1);

    // Address-terminated programming commands
    assign launch_a = last_a && ((opc == OPC_ERASE) ||
                                 ((opc == OPC_EXT) && (ext == EXT_ERALL)));

    // Read port request on the last address bit
    assign rd_req  = cs && last_a && (opc == OPC_READ);
    assign rd_word = org_wide ? a_full[AWW-1:0] : a_full[AWN-1:1];

    // Programming request toward the controller
    assign req_valid = cs && prog_en && (launch_a || last_d);
    assign req_addr  = (st == FS_DATA) ? asr : a_full;
    assign req_data  = d_full;
    always_comb begin
        if (st == FS_DATA) begin
            req_op = (opc == OPC_WRITE) ? PO_WRITE : PO_WRALL;
        end else begin
            req_op = (opc == OPC_ERASE) ? PO_ERASE : PO_ERALL;
        end
    end

    // Output: read stream, or ready status after a programming launch
    assign dout_oe = cs && (show_stat || (st == FS_READ));
    always_comb begin
        if (st == FS_READ) begin
            if (dummy) begin
                dout = 1'b0;
            end else begin
                dout = org_wide ? osr[WIDTH-1] : osr[NW-1];
            end
        end else begin
            dout = ~busy;
        end
    end

    // Frame sequencing, field shifting and enable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FS_IDLE;
            cnt       <= '0;
            opc       <= 2'b00;
            asr       <= '0;
            dsr       <= '0;
            osr       <= '0;
            dummy     <= 1'b0;
            lane      <= 1'b0;
            prog_en   <= 1'b0;
            show_stat <= 1'b0;
        end else if (!cs) begin
            st    <= FS_IDLE;
            cnt   <= '0;
            opc   <= 2'b00;
            asr   <= '0;
            dsr   <= '0;
            dummy <= 1'b0;
        end else begin
            case (st)
                FS_IDLE: begin
                    if (din && !busy) begin
                        st        <= FS_OPC;
                        cnt       <= '0;
                        show_stat <= 1'b0;
                    end
                end
                FS_OPC: begin
                    opc <= {opc[0], din};
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(1)) begin
                        st  <= FS_ADDR;
                        cnt <= '0;
                    end
                end
                FS_ADDR: begin
                    asr <= a_full;
                    cnt <= cnt + 1'b1;
                    if (last_a) begin
                        cnt <= '0;
                        case (opc)
                            OPC_READ: begin
                                st    <= FS_READ;
                                dummy <= 1'b1;
                                lane  <= a_full[0];
                            end
                            OPC_WRITE: st <= FS_DATA;
                            OPC_ERASE: begin
                                st <= FS_HOLD;
                                if (prog_en) show_stat <= 1'b1;
                            end
                            default: begin
                                case (ext)
                                    EXT_EN: begin
                                        prog_en <= 1'b1;
                                        st      <= FS_HOLD;
                                    end
                                    EXT_DIS: begin
                                        prog_en <= 1'b0;
                                        st      <= FS_HOLD;
                                    end
                                    EXT_ERALL: begin
                                        st <= FS_HOLD;
                                        if (prog_en) show_stat <= 1'b1;
                                    end
                                    default: st <= FS_DATA;
                                endcase
                            end
                        endcase
                    end
                end
                FS_DATA: begin
                    dsr <= d_full[WIDTH-2:0];
                    cnt <= cnt + 1'b1;
                    if (last_d) begin
                        st <= FS_HOLD;
                        if (prog_en) show_stat <= 1'b1;
                    end
                end
                FS_READ: begin
                    if (dummy) begin
                        dummy <= 1'b0;
                        cnt   <= '0;
                        if (org_wide) begin
                            osr <= rd_q;
                        end else begin
                            osr <= {{(WIDTH-NW){1'b0}},
                                    (lane ? rd_q[WIDTH-1:NW] : rd_q[NW-1:0])};
                        end
                    end else begin
                        osr <= {osr[WIDTH-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                        if (cnt == dw - 1'b1) begin
                            st <= FS_HOLD;
                        end
                    end
                end
                default: st <= FS_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/ser_eeprom_cmd.sv
// Top: serial EEPROM command front-end with program controller and array.
// Assumes: clk is the serial clock; everything here is in one clock domain.
module ser_eeprom_cmd
    import ser_eeprom_pkg::*;
#(
    parameter int WORDS       = 1024,
    parameter int WIDTH       = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic din,
    input  logic org_wide,
    output logic dout,
    output logic dout_oe
);
    localparam int AWW = $clog2(WORDS);

    logic             pc_busy;
    logic             rd_req;
    logic [AWW-1:0]   rd_word;
    logic [WIDTH-1:0] rd_q;
    logic             req_valid;
    pop_t             req_op;
    logic [AWW:0]     req_addr;
    logic [WIDTH-1:0] req_data;
    logic             ram_we;
    logic [1:0]       ram_be;
    logic [AWW-1:0]   ram_waddr;
    logic [WIDTH-1:0] ram_wdata;

    ser_eeprom_front #(.WORDS(WORDS), .WIDTH(WIDTH)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .din      (din),
        .org_wide (org_wide),
        .busy     (pc_busy),
        .rd_q     (rd_q),
        .rd_req   (rd_req),
        .rd_word  (rd_word),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_addr (req_addr),
        .req_data (req_data),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    ser_eeprom_prog #(.WORDS(WORDS), .WIDTH(WIDTH), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .org_wide (org_wide),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_addr (req_addr),
        .req_data (req_data),
        .busy     (pc_busy),
        .we       (ram_we),
        .wbe      (ram_be),
        .waddr    (ram_waddr),
        .wdata    (ram_wdata)
    );

    ser_eeprom_ram #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .wbe  (ram_be),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .re   (rd_req),
        .raddr(rd_word),
        .rdata(rd_q)
    );

endmodule

// File: rtl/ser_eeprom_cmd_chk.sv
// Protocol checker for ser_eeprom_cmd, attached by bind.
// Assumes: reset is asserted from time zero.
module ser_eeprom_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic dout_oe,
    input logic req_valid,
    input logic busy,
    input logic rd_req
);

    AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> busy); // R5

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R6

    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_valid); // R11

    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (!cs || (dout_oe && !dout))); // R4

    AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dout_oe) |-> !dout); // R10

endmodule

bind ser_eeprom_cmd ser_eeprom_cmd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .req_valid(req_valid),
    .busy     (pc_busy),
    .rd_req   (rd_req)
);

// File: tb/ser_eeprom_cmd_test.sv
`timescale 1ns/1ps
// Bench: behavioural array model and per-edge output expectations.
module ser_eeprom_cmd_test;
    localparam int WORDS = 1024;
    localparam int PROG  = 8;

    logic clk = 1'b0;
    logic rst_n, cs, din, org_wide;
    logic dout, dout_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] mem_m [WORDS];
    bit en_m = 0;

    always #5 clk = ~clk;

    ser_eeprom_cmd uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .din(din),
        .org_wide(org_wide), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input logic got, input logic exp, input string rq, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: %s got %b exp %b at %0t", rq, what, got, exp, $time);
        end
    endtask

    // One serial bit: drive at falling edge, sample after the rising edge
    task automatic step(input logic c, input logic d, input logic eoe, input logic edo, input string rq);
        cs  = c;
        din = d;
        @(posedge clk);
        #2;
        check(dout_oe, eoe, rq, "dout_oe");
        if (eoe) check(dout, edo, rq, "dout");
        @(negedge clk);
    endtask

    function automatic int aw_b();
        return org_wide ? 10 : 11;
    endfunction

    function automatic int dw_b();
        return org_wide ? 16 : 8;
    endfunction

    task automatic mk(input logic [1:0] op, input int addr, input int data, input bit with_d,
                      output logic [31:0] v, output int n);
        v = 32'd1;
        v = (v << 2) | op;
        v = (v << aw_b()) | addr;
        n = 3 + aw_b();
        if (with_d) begin
            v = (v << dw_b()) | data;
            n = n + dw_b();
        end
    endtask

    task automatic frame(input logic [31:0] v, input int n, input logic loe, input logic ldo, input string rq);
        for (int i = n - 1; i >= 1; i--) step(1'b1, v[i], 1'b0, 1'b0, rq);
        step(1'b1, v[0], loe, ldo, rq);
    endtask

    task automatic do_prog(input logic [31:0] v, input int n, input int dur, input string rq);
        if (en_m) begin
            frame(v, n, 1'b1, 1'b0, rq);
            for (int k = 1; k <= dur; k++) step(1'b1, 1'b0, 1'b1, (k >= dur), rq);
        end else begin
            frame(v, n, 1'b0, 1'b0, rq);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, rq);
    endtask

    function automatic logic [15:0] exp_rd(input int a);
        logic [15:0] w;
        if (org_wide) return mem_m[a];
        w = mem_m[a >> 1];
        return (a % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic model_wr(input int a, input logic [15:0] d);
        if (org_wide) mem_m[a] = d;
        else if (a % 2 == 1) mem_m[a >> 1][15:8] = d[7:0];
        else mem_m[a >> 1][7:0] = d[7:0];
    endtask

    task automatic rd(input int a, input string rq);
        logic [31:0] v;
        int n;
        logic [15:0] e;
        e = exp_rd(a);
        mk(2'b10, a, 0, 0, v, n);
        frame(v, n, 1'b1, 1'b0, rq);
        for (int i = dw_b() - 1; i >= 0; i--) step(1'b1, 1'b0, 1'b1, e[i], rq);
        step(1'b1, 1'b0, 1'b0, 1'b0, rq);
        step(1'b0, 1'b0, 1'b0, 1'b0, rq);
    endtask

    task automatic wr(input int a, input logic [15:0] d, input string rq);
        logic [31:0] v;
        int n;
        mk(2'b01, a, d, 1, v, n);
        do_prog(v, n, PROG, rq);
        if (en_m) model_wr(a, d);
    endtask

    task automatic er(input int a, input string rq);
        logic [31:0] v;
        int n;
        mk(2'b11, a, 0, 0, v, n);
        do_prog(v, n, PROG, rq);
        if (en_m) model_wr(a, 16'hFFFF);
    endtask

    task automatic ext(input logic [1:0] code, input string rq);
        logic [31:0] v;
        int n;
        mk(2'b00, int'(code) << (aw_b() - 2), 0, 0, v, n);
        frame(v, n, 1'b0, 1'b0, rq);
        step(1'b0, 1'b0, 1'b0, 1'b0, rq);
        if (code == 2'b11) en_m = 1;
        if (code == 2'b00) en_m = 0;
    endtask

    task automatic eral(input string rq);
        logic [31:0] v;
        int n;
        mk(2'b00, 2 << (aw_b() - 2), 0, 0, v, n);
        do_prog(v, n, WORDS, rq);
        if (en_m) for (int i = 0; i < WORDS; i++) mem_m[i] = 16'hFFFF;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish got timeout exp finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        rst_n = 0; cs = 0; din = 0; org_wide = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout_oe, 1'b0, "R8", "reset output off");
        rst_n = 1;
        step(1'b1, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");

        // R9: disabled at reset, erase ignored
        er(3, "R9");
        ext(2'b11, "R2");
        eral("R6");
        rd(0, "R6");
        rd(1023, "R6");

        wr(5, 16'hA5C3, "R5");
        rd(5, "R4");
        rd(6, "R4");

        // R1: leading zeros then read
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        rd(5, "R1");

        er(5, "R5");
        rd(5, "R5");

        // R10: chip select toggled while a write is busy
        mk(2'b01, 7, 16'h1234, 1, v, n);
        frame(v, n, 1'b1, 1'b0, "R10");
        for (int k = 1; k <= PROG; k++) begin
            logic c;
            c = (k == 3 || k == 4) ? 1'b0 : 1'b1;
            step(c, 1'b0, c, (k >= PROG), "R10");
        end
        step(1'b1, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
        model_wr(7, 16'h1234);
        rd(7, "R10");

        // R11: write-all with a burst of ones clocked in while busy
        mk(2'b00, 1 << 8, 16'h00FF, 1, v, n);
        frame(v, n, 1'b1, 1'b0, "R11");
        for (int k = 1; k <= WORDS; k++)
            step(1'b1, (k >= 2 && k <= 20), 1'b1, (k >= WORDS), "R11");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R11");
        for (int i = 0; i < WORDS; i++) mem_m[i] = 16'h00FF;
        rd(1023, "R11");
        rd(7, "R6");

        // R7: cancelled write
        mk(2'b01, 5, 16'hBEEF, 1, v, n);
        for (int i = n - 1; i >= 1; i--) step(1'b1, v[i], 1'b0, 1'b0, "R7");
        step(1'b0, v[0], 1'b0, 1'b0, "R7");
        rd(5, "R7");

        // R8: partial read cut by chip select, then a fresh read
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        rd(7, "R8");

        // R9: disable, then programming does nothing
        ext(2'b00, "R9");
        wr(5, 16'h1357, "R9");
        er(7, "R9");
        rd(5, "R9");
        rd(7, "R9");

        // R3: byte organization
        org_wide = 0;
        ext(2'b11, "R3");
        wr(11, 16'h00A7, "R3");
        rd(11, "R3");
        rd(10, "R3");
        er(21, "R3");
        rd(21, "R3");
        rd(20, "R3");
        org_wide = 1;
        step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        rd(5, "R3");
        rd(10, "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule